// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block sits on the secondary side of a bus bridge, next to the queue that holds delayed-transaction completions. When a completion becomes the head entry of that queue, the block starts counting bus clocks. The count is abandoned if the original initiator repeats its request or if the entry leaves the head. If the count reaches the selected limit first, the block pulses a discard strobe so the queue can drop the stale entry. Optionally, it also pulses a system-error request toward the primary side.

A 16-bit control/status register sets the timer range and the error enable. It also holds a sticky expiry flag that software clears by writing 1, and a few compatibility bits that only store values or read as zero. The timeout is exactly 2^LONG_EXP clocks in long mode and 2^SHORT_EXP clocks in short mode. Both values lie inside the usual ranges of 2^15..2^16 and 2^10..2^11 clocks.

Top module: `discard_timer`

## Requirements
- R1: After synchronous active-low reset, `rd_data` reads 0000h and `discard` and `serr_req` are 0.
- R2: With bit 0 (short select) at 0, the timer arms on the first clock edge at which `head_valid` is sampled high while idle. `discard` then rises exactly 2^LONG_EXP edges after the arming edge.
- R3: With bit 0 at 1, `discard` rises exactly 2^SHORT_EXP edges after the arming edge.
- R4: An `init_retry` sampled high while counting stops the count. No discard follows while that head stays valid. A later head (after `head_valid` falls) re-arms from zero.
- R5: `head_valid` sampled low while counting abandons the count. The next arming restarts from zero and gives the full timeout.
- R6: `discard` is high for exactly one cycle. No further discard is issued until `head_valid` has been low and a new head arms the timer.
- R7: Bit 1 (expiry status) reads 1 from the cycle after a discard pulse. Writing 0 to bit 1 leaves it unchanged. Writing 1 to bit 1 clears it.
- R8: A write of 1 to bit 1 in the same cycle as a new expiry leaves bit 1 set.
- R9: `serr_req` pulses together with `discard` when bit 2 (error enable) is 1, and stays 0 when bit 2 is 0.
- R10: Bits 3 and 4 read back the last value written and have no effect on the timeout.
- R11: Bits 15:5 read 0 whatever is written, including bit 6 (fast back-to-back enable) and bit 7 (secondary bus reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the timer counts its rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| head_valid | input | 1 | A delayed completion is at the head of the queue |
| init_retry | input | 1 | The initiator has repeated the request of the head entry |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| discard | output | 1 | One-cycle strobe: drop the head entry |
| serr_req | output | 1 | One-cycle system-error request toward the primary side |

## Verification
The hardest case to reach from the ports is a write-one-to-clear that lands on the exact cycle the status is being set. The bench waits until it sees `discard` high at a falling edge, then drives the clearing write so that it meets the status update on the next rising edge. A second hard case is a stopped or abandoned count that must not expire later. Directed runs hold the head valid for well past the timeout after a retry. A seeded random phase then drops heads and issues retries at rates chosen so that expiries, retries and abandons all occur, and compares every cycle against a bench model.

// File: rtl/dtt_pkg.sv
// Shared definitions for the discard timer: counter states and register
// bit positions. Assumes a 16-bit register.
package dtt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } dtt_state_e;

    localparam int REG_W    = 16;
    localparam int BIT_SEL  = 0;   // short timeout select
    localparam int BIT_STAT = 1;   // expiry status, write 1 to clear
    localparam int BIT_SERR = 2;   // error request enable
    localparam int BIT_PRI  = 3;   // storage only
    localparam int BIT_VGA  = 4;   // storage only
endpackage

// File: rtl/dtt_counter.sv
// Head-of-queue discard counter. Arms when a head entry is seen while idle,
// counts until the limit selected by sel_short, and emits one-cycle expire and
// serr pulses. A retry or the loss of the head stops the count. Assumes that
// head_valid falls between successive head entries.
module dtt_counter #(
    parameter int LONG_EXP  = 15,
    parameter int SHORT_EXP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic head_valid,
    input  logic retry,
    input  logic sel_short,
    input  logic serr_en,
    output logic expire,
    output logic serr
);
    import dtt_pkg::*;

    localparam int CW = LONG_EXP + 1;
    localparam logic [CW-1:0] LONG_LAST  = CW'((64'd1 << LONG_EXP) - 64'd1);
    localparam logic [CW-1:0] SHORT_LAST = CW'((64'd1 << SHORT_EXP) - 64'd1);

    dtt_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Select the terminal count for the current mode.
    always_comb last = sel_short ? SHORT_LAST : LONG_LAST;

    // Arm, count, stop and expire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            expire <= 1'b0;
            serr   <= 1'b0;
        end else begin
            expire <= 1'b0;
            serr   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (head_valid) begin
                        state <= ST_COUNT;
                        cnt   <= '0;
                    end
                end
                ST_COUNT: begin
                    if (!head_valid) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (retry) begin
                        state <= ST_HOLD;
                        cnt   <= '0;
                    end else if (cnt >= last) begin
                        state  <= ST_HOLD;
                        cnt    <= '0;
                        expire <= 1'b1;
                        serr   <= serr_en;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!head_valid) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    assert_expire_from_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> ($past(state) == ST_COUNT) && $past(head_valid));
    assert_retry_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && head_valid && retry) |=> (!expire && state == ST_HOLD));
    assert_abandon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && !head_valid) |=> (!expire && state == ST_IDLE));
endmodule

// File: rtl/dtt_ctrl_reg.sv
// Control/status register of the discard timer. Holds the mode select, the
// error enable, two storage-only bits and the sticky expiry flag. Assumes
// that expire_evt is a one-cycle pulse.
module dtt_ctrl_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        expire_evt,
    output logic [15:0] rd_data,
    output logic        sel_short,
    output logic        serr_en
);
    import dtt_pkg::*;

    logic stat, pri, vga;
    logic unused_bits;

    assign unused_bits = ^wr_data[15:5];

    // Plain read/write fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_short <= 1'b0;
            serr_en   <= 1'b0;
            pri       <= 1'b0;
            vga       <= 1'b0;
        end else if (wr_en) begin
            sel_short <= wr_data[BIT_SEL];
            serr_en   <= wr_data[BIT_SERR];
            pri       <= wr_data[BIT_PRI];
            vga       <= wr_data[BIT_VGA];
        end
    end

    // Sticky expiry flag; a new expiry beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                           stat <= 1'b0;
        else if (expire_evt)                  stat <= 1'b1;
        else if (wr_en && wr_data[BIT_STAT])  stat <= 1'b0;
    end

    // Assemble the read value; unlisted bits read as zero.
    always_comb begin
        rd_data           = '0;
        rd_data[BIT_SEL]  = sel_short;
        rd_data[BIT_STAT] = stat;
        rd_data[BIT_SERR] = serr_en;
        rd_data[BIT_PRI]  = pri;
        rd_data[BIT_VGA]  = vga;
    end

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:5] == 11'd0);
    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !(wr_en && wr_data[BIT_STAT])) |=> stat);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |=> stat);
endmodule

// File: rtl/discard_timer.sv
// Top of the delayed-transaction discard timer: joins the control register
// and the head-of-queue counter. Assumes that all inputs are synchronous to clk.
module discard_timer #(
    parameter int LONG_EXP  = 15,
    parameter int SHORT_EXP = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        head_valid,
    input  logic        init_retry,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        discard,
    output logic        serr_req
);
    logic sel_short, serr_en;

    dtt_ctrl_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .expire_evt (discard),
        .rd_data    (rd_data),
        .sel_short  (sel_short),
        .serr_en    (serr_en)
    );

    dtt_counter #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .retry      (init_retry),
        .sel_short  (sel_short),
        .serr_en    (serr_en),
        .expire     (discard),
        .serr       (serr_req)
    );

    assert_serr_with_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> discard);
    assert_serr_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> $past(serr_en));
endmodule

// File: tb/discard_timer_test.sv
module discard_timer_test;
    localparam int LONG_L  = 1 << 15;
    localparam int SHORT_L = 1 << 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid = 1'b0;
    logic        init_retry = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        discard, serr_req;

    int checks = 0, fails = 0;
    bit finished = 0;

    // bench reference model for the random phase
    bit model_on = 0, m_live = 0, m_done = 0, m_disc = 0, m_serr = 0, m_en = 0;
    int m_age = 0;

    always #5 clk = ~clk;

    discard_timer uut (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .init_retry(init_retry),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .discard(discard), .serr_req(serr_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    // Raise head_valid and expect discard exactly L edges after arming.
    task automatic arm_expect(input int l, input string tag, input logic serr_exp);
        head_valid = 1'b1;
        cyc(l);
        chk({tag, " no early discard"}, discard, 0);
        cyc(1);
        chk({tag, " discard"}, discard, 1);
        chk({tag, " serr"}, serr_req, serr_exp);
    endtask

    // Bench model: expected outputs derived from the requirements.
    always @(posedge clk) begin
        if (model_on) begin
            m_disc <= 0; m_serr <= 0;
            if (!head_valid) begin
                m_live <= 0; m_done <= 0;
            end else if (!m_live && !m_done) begin
                m_live <= 1; m_age <= 0;
            end else if (m_live) begin
                if (init_retry) begin
                    m_live <= 0; m_done <= 1;
                end else if (m_age == SHORT_L - 1) begin
                    m_disc <= 1; m_serr <= m_en; m_live <= 0; m_done <= 1;
                end else begin
                    m_age <= m_age + 1;
                end
            end
        end
    end

    initial begin
        #(195000 * 10);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk("R1 discard", discard, 0);
        chk("R1 serr", serr_req, 0);

        // R11/R10: all ones written; bit 1 write-1 clears, reserved read zero
        write_reg(16'hFFFF);
        chk("R11 reserved zero", rd_data, 16'h001D);
        write_reg(16'h0005);
        chk("R10 storage bits follow writes", rd_data, 16'h0005);
        write_reg(16'h001D);
        chk("R10 storage bits set", rd_data, 16'h001D);

        // R3/R9/R10: short mode, error enabled, storage bits set
        arm_expect(SHORT_L, "R3", 1);
        cyc(1);
        chk("R6 pulse width", discard, 0);
        chk("R7 status set", rd_data[1], 1);
        seen = 0;
        for (int i = 0; i < 1200; i++) begin cyc(1); if (discard) seen++; end
        chk("R6 no second discard", seen, 0);
        write_reg(16'h001D);
        chk("R7 write 0 keeps status", rd_data[1], 1);
        write_reg(16'h001F);
        chk("R7 write 1 clears", rd_data, 16'h001D);
        head_valid = 1'b0; cyc(2);

        // R9 off, R8 clear colliding with expiry
        write_reg(16'h0019);
        arm_expect(SHORT_L, "R9 disabled", 0);
        wr_en = 1'b1; wr_data = 16'h001B;
        cyc(1);
        wr_en = 1'b0;
        chk("R8 set wins over clear", rd_data[1], 1);
        write_reg(16'h001B);
        chk("R7 cleared", rd_data[1], 0);
        head_valid = 1'b0; cyc(2);

        // R4: retry stops the count
        head_valid = 1'b1; cyc(500);
        init_retry = 1'b1; cyc(1); init_retry = 1'b0;
        seen = 0;
        for (int i = 0; i < 2000; i++) begin cyc(1); if (discard) seen++; end
        chk("R4 no discard after retry", seen, 0);
        head_valid = 1'b0; cyc(2);
        arm_expect(SHORT_L, "R4 rearm", 0);
        head_valid = 1'b0; cyc(2);

        // R5: abandoned count restarts from zero
        head_valid = 1'b1; cyc(600);
        head_valid = 1'b0; cyc(1);
        chk("R5 no discard on drop", discard, 0);
        arm_expect(SHORT_L, "R5 restart", 0);
        head_valid = 1'b0; cyc(2);

        // R2: long mode
        write_reg(16'h0002);
        chk("R2 long mode reg", rd_data, 16'h0000);
        arm_expect(LONG_L, "R2", 0);
        cyc(1);
        chk("R2 status", rd_data[1], 1);
        head_valid = 1'b0;
        write_reg(16'h0003);

        // random phase in short mode, error enable on then off
        for (int half = 0; half < 2; half++) begin
            write_reg(half == 0 ? 16'h0007 : 16'h0003);
            m_en = (half == 0);
            head_valid = 1'b0; cyc(2);
            m_live = 0; m_done = 0; m_disc = 0; m_serr = 0;
            model_on = 1;
            for (int i = 0; i < 10000; i++) begin
                if (($urandom % 1500) == 0) head_valid = ~head_valid;
                else if (!head_valid && ($urandom % 20) == 0) head_valid = 1'b1;
                init_retry = (($urandom % 700) == 0);
                cyc(1);
                chk("R2-model discard", discard, m_disc);
                chk("R9 model serr", serr_req, m_serr);
            end
            model_on = 0;
            init_retry = 1'b0;
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule